// File: doc/BRIEF.md
# Segment Selector Translator with Cached Descriptors

This block converts a segment-relative offset into a linear address. It has six segment slots. Software loads a 16-bit selector into a slot. The index field of that selector names one eight-byte entry in a descriptor table held in memory. For a non-zero index, the block reads that entry once through a request/acknowledge read port. It then keeps the entry's base, limit and granularity flag in a hidden per-slot cache.

After that, each access names a slot and an offset. The block answers one cycle later with the base plus the offset, or with a fault when the offset lies beyond the slot's effective limit. Accesses never touch memory.

While a table read is outstanding, `busy` is high. Accesses to the slot being filled are held off, and accesses to other slots still proceed. A selector whose index is zero makes the slot null. Every access through a null slot faults.

Top module: `seg_xlate`

## Requirements
- R1: The selector index is bits 15:3. Bits 2:0 are ignored. A load with a non-zero index to slot 0..5 while idle raises `busy` and `rd_req` on the next cycle, with `rd_addr` = TABLE_BASE + index*8. Both stay high and `rd_addr` stays unchanged until the cycle `rd_ack` is sampled. They are low on the cycle after that.
- R2: The returned 64-bit descriptor word is decoded as follows: base in bits 31:0, a 20-bit limit in bits 51:32, and the granularity flag in bit 52. Bits 63:53 have no effect.
- R3: An accepted access produces `out_valid` one cycle later. When it does not fault, `out_lin` = base + offset, taken modulo 2^32.
- R4: With the granularity flag clear, the effective limit is the limit itself. An offset greater than it faults, and an offset equal to it does not.
- R5: With the granularity flag set, the effective limit is limit*4096 + 4095, and the same comparison applies.
- R6: A faulting access drives `out_lin` to zero. `out_fault` is high only together with `out_valid`.
- R7: A load whose index is zero makes the slot null without any table read. `busy` and `rd_req` stay low, and later accesses through that slot fault.
- R8: After reset, every slot is null, `busy`, `rd_req` and `out_valid` are low, and every access faults.
- R9: While a read is outstanding, an access to the slot being filled produces no `out_valid`. An access to any other slot is answered normally.
- R10: A selector load presented while `busy` is high is ignored. It leaves the target slot's cached descriptor unchanged.
- R11: Accesses never raise `rd_req`.
- R12: Slot numbers 6 and 7 are invalid. A load to them is ignored (no read, `busy` stays low), and an access to them faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Selector load strobe |
| ld_reg | input | 3 | Slot to load |
| ld_sel | input | 16 | Selector value |
| rd_req | output | 1 | Table read request, held until acknowledged |
| rd_addr | output | 32 | Byte address of the descriptor entry |
| rd_ack | input | 1 | Read acknowledge, with data valid |
| rd_data | input | 64 | Descriptor word |
| acc_valid | input | 1 | Access strobe |
| acc_reg | input | 3 | Slot used by the access |
| acc_ofs | input | 32 | Offset within the segment |
| out_valid | output | 1 | Translation result valid |
| out_lin | output | 32 | Linear address, zero on fault |
| out_fault | output | 1 | Limit or null fault |
| busy | output | 1 | Descriptor read outstanding |

## Verification
The checker assumes that the memory side asserts `rd_ack` only while `rd_req` is high, and that `rd_data` is valid in that same cycle. The bench's memory model only ever acknowledges an outstanding request, and it holds the acknowledge for exactly one cycle.

The stall property follows the slot being filled by watching the load port. This relies on loads presented while busy being dropped. The bench presents such loads on purpose, but only to other slots, so that the dropped load's effect can be read back later through ordinary accesses.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int SEG_ADDR_W = 32;
  localparam int SEG_LIM_W  = 20;
  localparam int SEG_PG_SH  = 12;
  localparam int SEG_DESC_W = 64;

  typedef struct packed {
    logic [SEG_ADDR_W-1:0] base;
    logic [SEG_LIM_W-1:0]  limit;
    logic                  gran;
    logic                  present;
  } seg_desc_t;

  function automatic seg_desc_t desc_unpack(input logic [SEG_DESC_W-1:0] w);
    seg_desc_t d;
    d.base    = w[SEG_ADDR_W-1:0];
    d.limit   = w[SEG_ADDR_W +: SEG_LIM_W];
    d.gran    = w[SEG_ADDR_W + SEG_LIM_W];
    d.present = 1'b1;
    return d;
  endfunction
endpackage

// File: rtl/seg_fetch.sv
module seg_fetch
  import seg_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int REG_W   = 3,
  parameter int SEL_W   = 16,
  parameter logic [SEG_ADDR_W-1:0] TABLE_BASE = 32'h0000_8000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ld_valid,
  input  logic [REG_W-1:0]      ld_reg,
  input  logic [SEL_W-1:0]      ld_sel,
  input  logic                  rd_ack,
  input  logic [SEG_DESC_W-1:0] rd_data,
  output logic                  busy,
  output logic [SEG_ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]      pend_reg,
  output logic                  wr_en,
  output logic [REG_W-1:0]      wr_idx,
  output seg_desc_t             wr_desc
);
  localparam int IDX_W = SEL_W - 3;
  localparam logic [REG_W:0] NSEG = NUM_SEG[REG_W:0];

  logic             busy_q;
  logic [IDX_W-1:0] idx;
  logic             ld_ok, ld_null, ld_fetch;

  assign idx      = ld_sel[SEL_W-1:3];
  assign ld_ok    = ld_valid && !busy_q && ({1'b0, ld_reg} < NSEG);
  assign ld_null  = ld_ok && (idx == '0);
  assign ld_fetch = ld_ok && (idx != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      rd_addr  <= '0;
      pend_reg <= '0;
    end else if (ld_fetch) begin
      busy_q   <= 1'b1;
      rd_addr  <= TABLE_BASE + SEG_ADDR_W'({idx, 3'b000});
      pend_reg <= ld_reg;
    end else if (busy_q && rd_ack) begin
      busy_q   <= 1'b0;
    end
  end

  assign busy    = busy_q;
  assign wr_en   = ld_null || (busy_q && rd_ack);
  assign wr_idx  = busy_q ? pend_reg : ld_reg;
  assign wr_desc = busy_q ? desc_unpack(rd_data) : '0;
endmodule

// File: rtl/seg_cache.sv
module seg_cache
  import seg_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int REG_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_idx,
  input  seg_desc_t        wr_desc,
  input  logic [REG_W-1:0] rd_idx,
  output seg_desc_t        rd_desc
);
  seg_desc_t ent [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)
        ent[g] <= '0;
      else if (wr_en && wr_idx == REG_W'(g))
        ent[g] <= wr_desc;
    end
  end

  always_comb begin
    rd_desc = '0;
    for (int i = 0; i < NUM_SEG; i++)
      if (rd_idx == REG_W'(i)) rd_desc = ent[i];
  end
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_pkg::*;
#(
  parameter int OFS_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  go,
  input  logic                  reg_ok,
  input  seg_desc_t             desc,
  input  logic [OFS_W-1:0]      ofs,
  output logic                  out_valid,
  output logic [SEG_ADDR_W-1:0] out_lin,
  output logic                  out_fault
);
  localparam int EFF_W = SEG_LIM_W + SEG_PG_SH;

  logic [EFF_W-1:0] lim_pg;
  logic [OFS_W-1:0] lim_eff;
  logic             bad;

  assign lim_pg  = {desc.limit, {SEG_PG_SH{1'b1}}};
  assign lim_eff = desc.gran ? OFS_W'(lim_pg) : OFS_W'(desc.limit);
  assign bad     = !reg_ok || !desc.present || (ofs > lim_eff);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_fault <= 1'b0;
      out_lin   <= '0;
    end else begin
      out_valid <= go;
      out_fault <= go && bad;
      out_lin   <= (go && !bad) ? desc.base + SEG_ADDR_W'(ofs) : '0;
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int REG_W   = 3,
  parameter int SEL_W   = 16,
  parameter int OFS_W   = 32,
  parameter logic [SEG_ADDR_W-1:0] TABLE_BASE = 32'h0000_8000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ld_valid,
  input  logic [REG_W-1:0]      ld_reg,
  input  logic [SEL_W-1:0]      ld_sel,
  output logic                  rd_req,
  output logic [SEG_ADDR_W-1:0] rd_addr,
  input  logic                  rd_ack,
  input  logic [SEG_DESC_W-1:0] rd_data,
  input  logic                  acc_valid,
  input  logic [REG_W-1:0]      acc_reg,
  input  logic [OFS_W-1:0]      acc_ofs,
  output logic                  out_valid,
  output logic [SEG_ADDR_W-1:0] out_lin,
  output logic                  out_fault,
  output logic                  busy
);
  localparam logic [REG_W:0] NSEG = NUM_SEG[REG_W:0];

  logic             wr_en;
  logic [REG_W-1:0] wr_idx, pend_reg;
  seg_desc_t        wr_desc, rd_desc;
  logic             stall, go, reg_ok;

  seg_fetch #(.NUM_SEG(NUM_SEG), .REG_W(REG_W), .SEL_W(SEL_W),
              .TABLE_BASE(TABLE_BASE)) u_fetch (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_reg(ld_reg),
    .ld_sel(ld_sel), .rd_ack(rd_ack), .rd_data(rd_data), .busy(busy),
    .rd_addr(rd_addr), .pend_reg(pend_reg), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_desc(wr_desc)
  );

  seg_cache #(.NUM_SEG(NUM_SEG), .REG_W(REG_W)) u_cache (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_desc(wr_desc), .rd_idx(acc_reg), .rd_desc(rd_desc)
  );

  assign rd_req = busy;
  assign stall  = busy && (acc_reg == pend_reg);
  assign go     = acc_valid && !stall;
  assign reg_ok = {1'b0, acc_reg} < NSEG;

  seg_check #(.OFS_W(OFS_W)) u_check (
    .clk(clk), .rst(rst), .go(go), .reg_ok(reg_ok), .desc(rd_desc),
    .ofs(acc_ofs), .out_valid(out_valid), .out_lin(out_lin),
    .out_fault(out_fault)
  );
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int NUM_SEG = 6,
  parameter int REG_W   = 3,
  parameter int SEL_W   = 16,
  parameter int OFS_W   = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             ld_valid,
  input logic [REG_W-1:0] ld_reg,
  input logic [SEL_W-1:0] ld_sel,
  input logic             rd_req,
  input logic [31:0]      rd_addr,
  input logic             rd_ack,
  input logic             acc_valid,
  input logic [REG_W-1:0] acc_reg,
  input logic             out_valid,
  input logic [31:0]      out_lin,
  input logic             out_fault,
  input logic             busy
);
  localparam logic [REG_W:0] NSEG = NUM_SEG[REG_W:0];

  logic             fetch_ld;
  logic [REG_W-1:0] chk_pend;

  assign fetch_ld = ld_valid && !busy && ({1'b0, ld_reg} < NSEG)
                    && (ld_sel[SEL_W-1:3] != '0);

  always_ff @(posedge clk) begin
    if (rst) chk_pend <= '0;
    else if (fetch_ld) chk_pend <= ld_reg;
  end

  assert_req_hold_R1: assert property (@(posedge clk) disable iff (rst)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));
  assert_req_drop_R1: assert property (@(posedge clk) disable iff (rst)
    rd_req && rd_ack |=> !busy);
  assert_fetch_start_R1: assert property (@(posedge clk) disable iff (rst)
    fetch_ld |=> busy && rd_req && rd_addr[2:0] == 3'b000);
  assert_null_load_R7: assert property (@(posedge clk) disable iff (rst)
    ld_valid && !busy && ld_sel[SEL_W-1:3] == '0 |=> !busy);
  assert_bad_slot_R12: assert property (@(posedge clk) disable iff (rst)
    ld_valid && !busy && ({1'b0, ld_reg} >= NSEG) |=> !busy);
  assert_fault_zero_R6: assert property (@(posedge clk) disable iff (rst)
    out_fault |-> out_valid && out_lin == '0);
  assert_answer_R3: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !busy |=> out_valid);
  assert_stall_R9: assert property (@(posedge clk) disable iff (rst)
    acc_valid && busy && acc_reg == chk_pend |=> !out_valid);
  assert_no_access_read_R11: assert property (@(posedge clk) disable iff (rst)
    !busy && !fetch_ld |=> !rd_req);
endmodule

bind seg_xlate seg_xlate_chk #(.NUM_SEG(NUM_SEG), .REG_W(REG_W),
                               .SEL_W(SEL_W), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_reg(ld_reg),
  .ld_sel(ld_sel), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
  .acc_valid(acc_valid), .acc_reg(acc_reg), .out_valid(out_valid),
  .out_lin(out_lin), .out_fault(out_fault), .busy(busy)
);

// File: tb/sim_seg_xlate.sv
module sim_seg_xlate;
  localparam logic [31:0] TB = 32'h0000_8000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_valid = 1'b0;
  logic [2:0]  ld_reg = '0;
  logic [15:0] ld_sel = '0;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_ack = 1'b0;
  logic [63:0] rd_data = '0;
  logic        acc_valid = 1'b0;
  logic [2:0]  acc_reg = '0;
  logic [31:0] acc_ofs = '0;
  logic        out_valid, out_fault, busy;
  logic [31:0] out_lin;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  seg_xlate u0 (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_reg(ld_reg),
    .ld_sel(ld_sel), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
    .rd_data(rd_data), .acc_valid(acc_valid), .acc_reg(acc_reg),
    .acc_ofs(acc_ofs), .out_valid(out_valid), .out_lin(out_lin),
    .out_fault(out_fault), .busy(busy)
  );

  // Model table: entry idx -> base, 20-bit limit, gran, with bits 63:53 all ones (R2)
  function automatic logic [31:0] m_base(input int idx);
    return 32'(idx) * 32'h0010_0000 + 32'(idx) * 32'h30;
  endfunction
  function automatic logic [19:0] m_lim(input int idx);
    return 20'(idx * 37 + 3);
  endfunction
  function automatic logic m_gran(input int idx);
    return 1'(idx >> 1);
  endfunction
  function automatic logic [31:0] m_eff(input int idx);
    return m_gran(idx) ? {m_lim(idx), 12'hFFF} : {12'h0, m_lim(idx)};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [2:0] r, input logic [31:0] ofs,
                        input logic exp_f, input logic [31:0] exp_l, input string req);
    acc_valid = 1'b1; acc_reg = r; acc_ofs = ofs;
    @(posedge clk); #1;
    acc_valid = 1'b0;
    chk({req, " valid"}, 64'(out_valid), 64'd1);
    chk({req, " fault"}, 64'(out_fault), 64'(exp_f));
    chk({req, " lin"}, 64'(out_lin), 64'(exp_l));
    chk("R11 no read on access", 64'(rd_req), 64'd0);
  endtask

  task automatic load(input logic [2:0] r, input int idx, input int wait_n);
    logic [2:0] oth;
    oth = (r == 3'd5) ? 3'd0 : r + 3'd1;
    ld_valid = 1'b1; ld_reg = r; ld_sel = {13'(idx), 3'b011};
    @(posedge clk); #1;
    ld_valid = 1'b0;
    chk("R1 busy after load", 64'(busy), 64'd1);
    chk("R1 rd_req after load", 64'(rd_req), 64'd1);
    chk("R1 rd_addr", 64'(rd_addr), 64'(TB + 32'(idx) * 32'd8));
    for (int k = 0; k < wait_n; k++) begin
      acc_valid = 1'b1; acc_ofs = 32'h0;
      acc_reg = (k % 2 == 0) ? r : oth;
      if (k == 0) begin
        ld_valid = 1'b1; ld_reg = oth; ld_sel = 16'h0148; // index 41, must be dropped (R10)
      end
      @(posedge clk); #1;
      acc_valid = 1'b0; ld_valid = 1'b0;
      if (k % 2 == 0) chk("R9 stalled slot", 64'(out_valid), 64'd0);
      else            chk("R9 other slot served", 64'(out_valid), 64'd1);
      chk("R1 request held", 64'(rd_addr), 64'(TB + 32'(idx) * 32'd8));
      chk("R1 rd_req held", 64'(rd_req), 64'd1);
    end
    rd_ack = 1'b1;
    rd_data = {11'h7FF, m_gran(idx), m_lim(idx), m_base(idx)};
    @(posedge clk); #1;
    rd_ack = 1'b0; rd_data = '0;
    chk("R1 busy drops after ack", 64'(busy), 64'd0);
    chk("R1 rd_req drops after ack", 64'(rd_req), 64'd0);
  endtask

  task automatic sweep(input logic [2:0] r, input int idx);
    logic [31:0] e;
    e = m_eff(idx);
    access(r, 32'h0, 1'b0, m_base(idx), "R3 offset zero");
    access(r, e - 32'd1, 1'b0, m_base(idx) + e - 32'd1, m_gran(idx) ? "R5 below limit" : "R4 below limit");
    access(r, e, 1'b0, m_base(idx) + e, m_gran(idx) ? "R5 at limit" : "R4 at limit");
    access(r, e + 32'd1, 1'b1, 32'h0, m_gran(idx) ? "R5 above limit R6" : "R4 above limit R6");
    access(r, 32'hFFFF_FFF0, 1'b1, 32'h0, "R6 far offset");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk("R8 busy at reset", 64'(busy), 64'd0);
    chk("R8 rd_req at reset", 64'(rd_req), 64'd0);
    chk("R8 out_valid at reset", 64'(out_valid), 64'd0);
    for (int r = 0; r < 6; r++) access(3'(r), 32'h0, 1'b1, 32'h0, "R8 null after reset");

    for (int r = 0; r < 6; r++) load(3'(r), r + 1, r);
    for (int r = 0; r < 6; r++) sweep(3'(r), r + 1);   // also shows dropped loads had no effect (R10, R2)

    // Null selector, index zero with nonzero low bits (R7)
    ld_valid = 1'b1; ld_reg = 3'd2; ld_sel = 16'h0003;
    @(posedge clk); #1;
    ld_valid = 1'b0;
    chk("R7 no busy on null", 64'(busy), 64'd0);
    chk("R7 no read on null", 64'(rd_req), 64'd0);
    access(3'd2, 32'h0, 1'b1, 32'h0, "R7 null slot faults");
    access(3'd1, 32'h4, 1'b0, m_base(2) + 32'h4, "R7 neighbour untouched");

    // Invalid slots (R12)
    for (int r = 6; r < 8; r++) begin
      ld_valid = 1'b1; ld_reg = 3'(r); ld_sel = 16'h0048;
      @(posedge clk); #1;
      ld_valid = 1'b0;
      chk("R12 load ignored", 64'(busy), 64'd0);
      access(3'(r), 32'h0, 1'b1, 32'h0, "R12 invalid slot faults");
    end

    // Highest index (R1 boundary), page granular entry
    load(3'd3, 8191, 2);
    sweep(3'd3, 8191);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule